// File: doc/BRIEF.md
# DRAM Refresh-Counter Self-Test Sequencer

This block is a built-in test engine for an asynchronous DRAM that has an internal refresh address counter. It drives the row strobe, column strobe, write enable, output enable, the multiplexed address pins and the data pins through a fixed procedure. That procedure shows whether the on-die counter visits every row exactly once and in order. All strobe timing is given in clock cycles through parameters, so one netlist can serve several speed grades.

After `start`, the sequencer first runs eight row-strobe-only cycles to bring the on-die counter to a known state. It then writes the pass pattern to one fixed column in every row with ordinary early writes. Next come the counter-test steps. Each one is a column-before-row refresh, in which the DRAM picks the row itself. The row strobe stays low, the column strobe is raised and then dropped a second time, and the sequencer reads the cell, checks it, raises output enable and writes the inverse. The row the DRAM picks is expected to follow an internal model counter that advances in the same order. A pass ends with ordinary reads of every row. The whole sequence is then repeated with the data inverted. The first mismatch stops the run, sets `fail` and reports the model row index.

The control and status pins are plain levels and pulses. The block has no streaming interface, so there is no back-pressure.

Top module: `dram_cnt_selftest`

## Requirements
- R1: While reset is held, and whenever the block is idle, all four strobes are high (inactive), `dq_oe` is 0, and `busy`, `done` and `fail` are 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. Exactly INIT_CYC (default 8) row-strobe-only cycles then follow before the first write. In these cycles the row strobe falls with the column strobe high, and the column strobe never falls.
- R3: Every column-strobe fall that occurs while the row strobe is low presents the parameter COL on the address pins.
- R4: In each pass, one early write is issued per row (write enable low before the column strobe falls), in ascending row order starting at 0. The pass data is all zeros in the first pass and all ones in the second.
- R5: Each counter-test step is as follows. The column strobe falls while the row strobe is high, and the row strobe then falls with write enable high. The row strobe stays low while the column strobe rises and falls again. The cell is read and checked, and then write enable falls, writing the inverse of the pass data. There are ROWS such steps per pass.
- R6: In a counter-test step, write enable falls no sooner than T_CT_CAC+T_OED cycles (default 18) after the second column-strobe fall.
- R7: Output enable is high whenever write enable falls, and whenever the block drives the data pins.
- R8: After the counter-test steps, every row is read with an ordinary read and checked against the inverse of the pass data.
- R9: The second pass repeats R4, R5 and R8 with inverted data. At the end of a clean run every cell holds all zeros.
- R10: A read mismatch sets `fail` and loads `fail_row` with the model row index of the failing step, where the index is the step number for a counter-test step and the row for a verify read. The run is then aborted. `fail` and `fail_row` hold until the next start.
- R11: `done` is a single-cycle pulse, issued exactly once per run, after the second verify pass or on abort. `busy` is low in that cycle.
- R12: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (used only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | A read mismatch occurred in the last run |
| fail_row | output | ROW_W | Model row index of the first mismatch |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dq_out | output | DQ_W | Data driven to the DRAM |
| dq_oe | output | 1 | Data pins driven by the block |
| dq_in | input | DQ_W | Data read from the DRAM |

## Verification
A behavioural DRAM model in the bench owns its own refresh counter, and it can skip a count or force a stuck data bit. A sequencer whose phase counter or op state is wrong shows this within one DRAM cycle. The symptoms are a strobe order the model counts as the wrong cycle type, a column strobe with a row address, or write enable falling while output enable is low. A wrong row index or pass polarity may not show until the next read of the affected row. That read is at most one pass later, and it surfaces as a wrong `fail`/`fail_row`, or as a final memory image that is not all zeros. A skipping counter is reported at the last counter-test step of the first pass, where the model wraps onto a row that was already inverted.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_INIT = 3'd1,
    OP_WR   = 3'd2,
    OP_CT   = 3'd3,
    OP_RD   = 3'd4
  } op_e;

  // One phase of a DRAM cycle: strobe levels plus sequencing flags
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic col_sel;
    logic drive;
    logic sample;
    logic last;
  } pins_t;

  localparam int PH_W = 3;
endpackage

// File: rtl/dts_cycle_dec.sv
module dts_cycle_dec
  import dts_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int T_RP     = 10,
  parameter int T_RAS    = 15,
  parameter int T_RCD    = 4,
  parameter int T_CAS    = 4,
  parameter int T_CAC    = 4,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 3,
  parameter int T_CP     = 3,
  parameter int T_CT_CAC = 9,
  parameter int T_OED    = 9,
  parameter int T_WP     = 5
) (
  input  op_e              op,
  input  logic [PH_W-1:0]  ph,
  output pins_t            pins,
  output logic [CNT_W-1:0] dur
);
  function automatic pins_t mk(input logic r, c, w, o, col, drv, smp, lst);
    mk = '{ras_n: r, cas_n: c, we_n: w, oe_n: o,
           col_sel: col, drive: drv, sample: smp, last: lst};
  endfunction

  always_comb begin
    pins = mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    dur  = CNT_W'(1);
    if (op != OP_IDLE && ph == '0) begin
      dur = CNT_W'(T_RP);                       // precharge, every cycle
      pins.last = 1'b0;
    end else begin
      unique case (op)
        OP_INIT: begin
          pins = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
          dur  = CNT_W'(T_RAS);
        end
        OP_WR: case (ph)
          3'd1:    begin pins = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); dur = CNT_W'(T_RCD); end
          3'd2:    begin pins = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); dur = CNT_W'(1); end
          default: begin pins = mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); dur = CNT_W'(T_CAS); end
        endcase
        OP_RD: case (ph)
          3'd1:    begin pins = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); dur = CNT_W'(T_RCD); end
          3'd2:    begin pins = mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); dur = CNT_W'(1); end
          default: begin pins = mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); dur = CNT_W'(T_CAC); end
        endcase
        OP_CT: case (ph)
          3'd1:    begin pins = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); dur = CNT_W'(T_CSR); end
          3'd2:    begin pins = mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); dur = CNT_W'(T_CHR); end
          3'd3:    begin pins = mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); dur = CNT_W'(T_CP); end
          3'd4:    begin pins = mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); dur = CNT_W'(T_CT_CAC); end
          3'd5:    begin pins = mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); dur = CNT_W'(T_OED); end
          default: begin pins = mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); dur = CNT_W'(T_WP); end
        endcase
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dts_phase_timer.sv
module dts_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] dur,
  output logic             ph_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt;

  assign ph_end = (cnt == dur - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || ph_end)    cnt <= '0;
    else                       cnt <= cnt + ONE;
  end
endmodule

// File: rtl/dram_cnt_selftest.sv
module dram_cnt_selftest
  import dts_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int DQ_W     = 4,
  parameter int ADDR_W   = 11,
  parameter int COL      = 341,
  parameter int INIT_CYC = 8,
  parameter int CNT_W    = 6,
  parameter int T_RP     = 10,
  parameter int T_RAS    = 15,
  parameter int T_RCD    = 4,
  parameter int T_CAS    = 4,
  parameter int T_CAC    = 4,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 3,
  parameter int T_CP     = 3,
  parameter int T_CT_CAC = 9,
  parameter int T_OED    = 9,
  parameter int T_WP     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ROW_W-1:0]  fail_row,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   dq_in
);
  localparam logic [ROW_W-1:0] ONE_ROW   = ROW_W'(1);
  localparam logic [ROW_W-1:0] LAST_ROW  = {ROW_W{1'b1}};
  localparam logic [ROW_W-1:0] INIT_LAST = ROW_W'(INIT_CYC - 1);
  localparam logic [ADDR_W-1:0] COL_ADDR = ADDR_W'(COL);

  op_e              op;
  logic [PH_W-1:0]  ph;
  logic [ROW_W-1:0] idx;     // row / step / init index, also the model counter
  logic             pol;     // pass data polarity
  pins_t            pins;
  logic [CNT_W-1:0] dur;
  logic             ph_end;
  logic [DQ_W-1:0]  exp_data;

  dts_cycle_dec #(
    .CNT_W(CNT_W), .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CAC(T_CAC), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_CP(T_CP),
    .T_CT_CAC(T_CT_CAC), .T_OED(T_OED), .T_WP(T_WP)
  ) dec_i (
    .op(op), .ph(ph), .pins(pins), .dur(dur)
  );

  dts_phase_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(op == OP_IDLE), .dur(dur), .ph_end(ph_end)
  );

  assign busy       = (op != OP_IDLE);
  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;
  assign dram_oe_n  = pins.oe_n;
  assign dq_oe      = pins.drive;
  assign dram_addr  = pins.col_sel ? COL_ADDR : ADDR_W'(idx);
  assign dq_out     = (op == OP_WR) ? {DQ_W{pol}}  : {DQ_W{~pol}};
  assign exp_data   = (op == OP_CT) ? {DQ_W{pol}}  : {DQ_W{~pol}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_IDLE; ph <= '0; idx <= '0; pol <= 1'b0;
      fail <= 1'b0; fail_row <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (op == OP_IDLE) begin
        if (start) begin
          op <= OP_INIT; ph <= '0; idx <= '0; pol <= 1'b0;
          fail <= 1'b0; fail_row <= '0;
        end
      end else if (ph_end) begin
        if (pins.sample && dq_in != exp_data) begin
          fail <= 1'b1; fail_row <= idx; op <= OP_IDLE; done <= 1'b1;
        end else if (!pins.last) begin
          ph <= ph + 3'd1;
        end else begin
          ph  <= '0;
          idx <= idx + ONE_ROW;
          unique case (op)
            OP_INIT: if (idx == INIT_LAST) begin op <= OP_WR; idx <= '0; end
            OP_WR:   if (idx == LAST_ROW) op <= OP_CT;
            OP_CT:   if (idx == LAST_ROW) op <= OP_RD;
            OP_RD:   if (idx == LAST_ROW) begin
                       if (!pol) begin pol <= 1'b1; op <= OP_WR; end
                       else begin op <= OP_IDLE; done <= 1'b1; end
                     end
            default: op <= OP_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dts_check.sv
module dts_check #(
  parameter int ADDR_W = 11,
  parameter int COL    = 341
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && we_n && oe_n && !dq_oe)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R2
  AST_COL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (addr == ADDR_W'(COL))); // R3
  AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> we_n); // R5
  AST_WE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> oe_n); // R7
  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R7
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(fail)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

bind dram_cnt_selftest dts_check #(.ADDR_W(ADDR_W), .COL(COL)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .oe_n(dram_oe_n), .dq_oe(dq_oe), .addr(dram_addr)
);

// File: tb/dram_cnt_selftest_tb_top.sv
module dram_cnt_selftest_tb_top;
  localparam int ROW_W = 4, ROWS = 16, DQ_W = 4, ADDR_W = 11, COL = 341;
  localparam int CWD_MIN = 18;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #2 clk = ~clk;

  logic busy, done, fail, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0]  fail_row;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0]   dq_out, dq_in, rd_val;

  dram_cnt_selftest #(.ROW_W(ROW_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W), .COL(COL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_row(fail_row), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // ---------------- DRAM model with its own refresh counter ----------------
  logic [DQ_W-1:0]  mem [ROWS];
  logic [ROW_W-1:0] refcnt, cur_row, wr_row;
  logic [1:0]       fault_mode = 2'd0;   // 0 none, 1 counter skip, 2 bit0 stuck-1, 3 bit0 stuck-0
  logic [ROW_W-1:0] fault_arg  = '0;
  logic p_ras, p_cas, p_we, ct, cas_seen, wrote_any;
  int n_done, n_ro_pre, n_colerr, n_wr, n_ord, n_cbr, n_cbrwe, n_ctrd, n_dwr;
  int n_rd, n_oeerr, n_conflict, n_drverr, n_ones, n_zeros, cas_cnt, min_cwd;

  always_comb begin
    rd_val = mem[cur_row];
    if (fault_mode == 2'd2 && cur_row == fault_arg) rd_val[0] = 1'b1;
    if (fault_mode == 2'd3 && cur_row == fault_arg) rd_val[0] = 1'b0;
  end
  assign dq_in = (!ras_n && !cas_n && !oe_n && we_n) ? rd_val : '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      refcnt <= '0; cur_row <= '0; wr_row <= '0;
      p_ras <= 1'b1; p_cas <= 1'b1; p_we <= 1'b1;
      ct <= 1'b0; cas_seen <= 1'b0; wrote_any <= 1'b0;
      n_done <= 0; n_ro_pre <= 0; n_colerr <= 0; n_wr <= 0; n_ord <= 0;
      n_cbr <= 0; n_cbrwe <= 0; n_ctrd <= 0; n_dwr <= 0; n_rd <= 0;
      n_oeerr <= 0; n_conflict <= 0; n_drverr <= 0; n_ones <= 0; n_zeros <= 0;
      cas_cnt <= 0; min_cwd <= 1000;
    end else begin
      p_ras <= ras_n; p_cas <= cas_n; p_we <= we_n;
      if (done) n_done <= n_done + 1;
      if (dq_oe && !oe_n) n_conflict <= n_conflict + 1;
      if (p_ras && !ras_n) begin
        cas_seen <= 1'b0;
        if (!cas_n) begin
          ct <= 1'b1; cur_row <= refcnt; n_cbr <= n_cbr + 1;
          refcnt <= refcnt + ((fault_mode == 2'd1 && refcnt == fault_arg) ? ROW_W'(2) : ROW_W'(1));
          if (!we_n) n_cbrwe <= n_cbrwe + 1;
        end else begin
          ct <= 1'b0; cur_row <= addr[ROW_W-1:0];
        end
      end
      if (!p_ras && ras_n && !cas_seen && !wrote_any) n_ro_pre <= n_ro_pre + 1;
      if (p_cas && !cas_n && !ras_n) begin
        cas_seen <= 1'b1; cas_cnt <= 0;
        if (addr != ADDR_W'(COL)) n_colerr <= n_colerr + 1;
        if (!we_n) begin
          n_wr <= n_wr + 1; wrote_any <= 1'b1; mem[cur_row] <= dq_out;
          if (cur_row != wr_row) n_ord <= n_ord + 1;
          wr_row <= wr_row + ROW_W'(1);
          if (dq_out == '1) n_ones <= n_ones + 1;
          else if (dq_out == '0) n_zeros <= n_zeros + 1;
          if (!dq_oe) n_drverr <= n_drverr + 1;
        end else if (ct) n_ctrd <= n_ctrd + 1;
        else n_rd <= n_rd + 1;
      end else if (!cas_n) cas_cnt <= cas_cnt + 1;
      if (p_we && !we_n && !cas_n && !ras_n) begin
        n_dwr <= n_dwr + 1; mem[cur_row] <= dq_out;
        if (!oe_n) n_oeerr <= n_oeerr + 1;
        if (!dq_oe) n_drverr <= n_drverr + 1;
        if (cas_cnt + 1 < min_cwd) min_cwd <= cas_cnt + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] arg;
    logic       efail;
    logic [7:0] erow;
  } vec_t;

  // clean run, counter skips (caught where the counter wraps), stuck bits (CT / verify)
  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd0, 1'b0, 8'd0},
    '{2'd1, 8'd5, 1'b1, 8'd15},
    '{2'd1, 8'd0, 1'b1, 8'd15},
    '{2'd2, 8'd3, 1'b1, 8'd3},
    '{2'd2, 8'd0, 1'b1, 8'd0},
    '{2'd3, 8'd6, 1'b1, 8'd6}
  };

  task automatic run_one(input logic [1:0] mode, input logic [ROW_W-1:0] arg, input bit extra_start);
    int cyc;
    rst_n = 1'b0; start = 1'b0; fault_mode = mode; fault_arg = arg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", busy, 1);
    cyc = 0;
    while (n_done == 0 && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (extra_start && (cyc == 300 || cyc == 1200)) start = 1'b1;   // R12
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic clean_checks(input string tag);
    chk({tag, " R2 row-only init cycles"}, n_ro_pre, 8);
    chk({tag, " R3 column address errors"}, n_colerr, 0);
    chk({tag, " R4 early writes"}, n_wr, 2 * ROWS);
    chk({tag, " R4 write row order errors"}, n_ord, 0);
    chk({tag, " R5 counter-test refreshes"}, n_cbr, 2 * ROWS);
    chk({tag, " R5 refresh with WE low"}, n_cbrwe, 0);
    chk({tag, " R5 counter-test reads"}, n_ctrd, 2 * ROWS);
    chk({tag, " R5 counter-test writes"}, n_dwr, 2 * ROWS);
    chk({tag, " R6 CAS-to-WE delay ok"}, (min_cwd >= CWD_MIN), 1);
    chk({tag, " R7 WE fall with OE low"}, n_oeerr, 0);
    chk({tag, " R7 drive with OE low"}, n_conflict + n_drverr, 0);
    chk({tag, " R8 verify reads"}, n_rd, 2 * ROWS);
    chk({tag, " R9 zero-data writes"}, n_zeros, ROWS);
    chk({tag, " R9 one-data writes"}, n_ones, ROWS);
    chk({tag, " R10 no fail"}, fail, 0);
    chk({tag, " R11 done count"}, n_done, 1);
    chk({tag, " R11 busy low at end"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk("R1 status idle in reset", {busy, done, fail, dq_oe}, 4'h0);

    foreach (VECS[i]) begin
      run_one(VECS[i].mode, VECS[i].arg[ROW_W-1:0], 1'b0);
      chk($sformatf("R10 vec%0d fail flag", i), fail, VECS[i].efail);
      if (VECS[i].efail) chk($sformatf("R10 vec%0d fail row", i), fail_row, VECS[i].erow);
      chk($sformatf("R11 vec%0d done pulses", i), n_done, 1);
      chk($sformatf("R1 vec%0d idle strobes", i), {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'h1E);
      if (!VECS[i].efail) begin
        clean_checks("vec0");
        for (int r = 0; r < ROWS; r++)
          chk($sformatf("R9 final cell row %0d", r), mem[r], 0);
      end
    end

    // R12: start pulses during a run change nothing
    run_one(2'd0, '0, 1'b1);
    clean_checks("R12 run");

    // R10: fail holds after a failing run while idle
    run_one(2'd2, ROW_W'(3), 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 fail holds while idle", fail, 1);
    chk("R10 fail_row holds while idle", fail_row, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule